// File: doc/BRIEF.md
# Write Buffer with Read-Miss Priority

This block sits between a write-through cache and a slower memory port. Every store from the cache is dropped into a small first-in first-out queue of address and data pairs. The cache counts the store as done as soon as the queue takes it, so it never waits out the memory write latency. The queue then drains its stores to memory one at a time, oldest first, over a single request port with a valid/ready handshake.

A read miss from the cache goes to memory ahead of the stores still waiting in the queue. Because a read may now overtake an older store to the same address, every read is compared against all valid queued entries. When one or more entries match, the data of the youngest matching entry is returned straight from the queue and memory is not touched. When nothing matches, a memory read is launched before any further store, and its returned data is passed back to the cache.

Top module: `wbuf_top`

## Requirements
- R1: A store is taken in the cycle that `wr_valid` is high and `wr_full` is low, with no dependence on the memory port. `wr_full` is high exactly when DEPTH entries sit in the queue. One more store may sit in the memory request register, so with memory stalled DEPTH+1 back-to-back stores are taken before `wr_full` rises.
- R2: After reset the queue is empty: `wr_full`=0, `rd_ready`=1, `mem_req_valid`=0, `rd_resp_valid`=0.
- R3: Queued stores reach memory in the order they were taken, as requests with `mem_req_write`=1 that carry their own address and data.
- R4: A read with no queued match makes a memory request with `mem_req_write`=0 and the read address. It is the next request launched after the read is taken, ahead of every store still in the queue. A store already presented on the port is not withdrawn.
- R5: A read whose address matches queued entries raises `rd_resp_valid` one cycle after it is taken, with the data of the youngest matching entry, and no memory read is made.
- R6: For a read sent to memory, `rd_resp_valid` is high for one cycle, one cycle after `mem_rsp_valid`, with `rd_resp_data` equal to `mem_rsp_data`.
- R7: From the cycle after a read is sent to memory until its data returns, `rd_ready` is low, and no store request is presented while the read is waiting for data.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request's valid, write flag, address and data hold.
- R9: A store taken in the same cycle as a read comes after that read. The read does not see it, and the store still reaches memory afterwards.
- R10: A store offered while `wr_full` is high is dropped and never reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store offered by the cache |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_full | output | 1 | Queue full; stores are refused |
| rd_valid | input | 1 | Read miss offered by the cache |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read can be taken this cycle |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Store data of the request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The assertions check on every cycle that the queue count stays in range and agrees with the valid bits, that no store is pushed when full and no pop happens when empty, that a stalled request holds steady, that a pending read launches as soon as the port frees up, and that no store is presented while a read waits for data. Only the bench scenarios can show which data is forwarded when several entries share an address, the order in which stores reach memory, the dropping of a store offered while full, and that a store taken in the same cycle as a read is ordered after that read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    REQ_READ  = 1'b0,
    REQ_WRITE = 1'b1
  } req_kind_e;
endpackage

// File: rtl/wbuf_queue.sv
// Store queue: circular array of address/data pairs with a parallel address snoop.
module wbuf_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  input  logic [AW-1:0] snoop_addr,
  output logic          snoop_hit,
  output logic [DW-1:0] snoop_data
);
  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  // payload storage: no reset, one write port
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wp] <= push_addr;
      data_mem[wp] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        vld[wp] <= 1'b1;
        wp      <= wp + 1'b1;
      end
      if (pop) begin
        vld[rp] <= 1'b0;
        rp      <= rp + 1'b1;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign head_addr = addr_mem[rp];
  assign head_data = data_mem[rp];

  // walk oldest to youngest so the last match is the youngest
  always_comb begin
    snoop_hit  = 1'b0;
    snoop_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] idx;
      idx = rp + PW'(i);
      if (vld[idx] && addr_mem[idx] == snoop_addr) begin
        snoop_hit  = 1'b1;
        snoop_data = data_mem[idx];
      end
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r1_count_matches_valid: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) == int'(cnt));
  a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wbuf_memport.sv
// Memory request register and read-miss sequencing; reads go ahead of stores.
module wbuf_memport
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          miss_start,
  input  logic [AW-1:0] miss_addr,
  output logic          rd_busy,
  output logic          rd_done,
  input  logic          wr_avail,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          pop,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid
);
  logic          req_v;
  req_kind_e     req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          rd_pend, rd_wait;
  logic [AW-1:0] rd_addr_q;
  logic          port_free, load_rd, load_wr;

  assign port_free = !req_v || mem_req_ready;
  assign load_rd   = port_free && rd_pend;
  assign load_wr   = port_free && !rd_pend && !rd_wait && !miss_start && wr_avail;
  assign pop       = load_wr;
  assign rd_busy   = rd_pend || rd_wait;
  assign rd_done   = rd_wait && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v     <= 1'b0;
      req_kind  <= REQ_READ;
      req_addr  <= '0;
      req_data  <= '0;
      rd_pend   <= 1'b0;
      rd_wait   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (miss_start) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= miss_addr;
      end
      if (load_rd) begin
        req_v    <= 1'b1;
        req_kind <= REQ_READ;
        req_addr <= rd_addr_q;
        rd_pend  <= 1'b0;
        rd_wait  <= 1'b1;
      end else if (load_wr) begin
        req_v    <= 1'b1;
        req_kind <= REQ_WRITE;
        req_addr <= head_addr;
        req_data <= head_data;
      end else if (mem_req_ready) begin
        req_v <= 1'b0;
      end
      if (rd_done) rd_wait <= 1'b0;
    end
  end

  assign mem_req_valid = req_v;
  assign mem_req_write = (req_kind == REQ_WRITE);
  assign mem_req_addr  = req_addr;
  assign mem_req_wdata = req_data;

  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata));
  a_r4_read_launch: assert property (@(posedge clk) disable iff (rst)
    rd_pend && port_free |=> mem_req_valid && !mem_req_write);
  a_r7_no_store_while_waiting: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> !(mem_req_valid && mem_req_write));
  a_r7_one_read_at_a_time: assert property (@(posedge clk) disable iff (rst)
    miss_start |-> !rd_pend && !rd_wait);
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  logic          push, pop, q_full, q_empty, hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;
  logic          rd_busy, rd_done, rd_accept, miss_start;

  assign push       = wr_valid && !q_full;
  assign wr_full    = q_full;
  assign rd_ready   = !rd_busy;
  assign rd_accept  = rd_valid && rd_ready;
  assign miss_start = rd_accept && !hit;

  wbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(pop), .head_addr(head_addr), .head_data(head_data),
    .full(q_full), .empty(q_empty),
    .snoop_addr(rd_addr), .snoop_hit(hit), .snoop_data(hit_data)
  );

  wbuf_memport #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst),
    .miss_start(miss_start), .miss_addr(rd_addr),
    .rd_busy(rd_busy), .rd_done(rd_done),
    .wr_avail(!q_empty), .head_addr(head_addr), .head_data(head_data), .pop(pop),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= (rd_accept && hit) || rd_done;
      if (rd_accept && hit) rd_resp_data <= hit_data;
      else if (rd_done)     rd_resp_data <= mem_rsp_data;
    end
  end

  a_r5_forward_next_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_accept && hit |=> rd_resp_valid && rd_ready);
  a_r6_return_after_rsp: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> rd_resp_valid && rd_resp_data == $past(mem_rsp_data));
  a_r7_ready_drops_on_miss: assert property (@(posedge clk) disable iff (rst)
    miss_start |=> !rd_ready);
endmodule

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;
  localparam int AW = 16, DW = 32, LAT = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, rd_valid = 0, ready_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, rd_ready, rd_resp_valid, mem_req_valid, mem_req_write, mem_rsp_valid;
  logic [DW-1:0] rd_resp_data, mem_req_wdata, mem_rsp_data;
  logic [AW-1:0] mem_req_addr;

  always #10 clk = ~clk;

  wbuf_top #(.AW(AW), .DW(DW), .DEPTH(4)) u_wbuf_top (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_full(wr_full), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(ready_en), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model with handshake log
  logic [DW-1:0] model [16];
  logic          lg_we  [64];
  logic [AW-1:0] lg_a   [64];
  logic [DW-1:0] lg_d   [64];
  int            lg_cyc [64];
  int lg_n = 0, cyc = 0, rsp_cnt = 0;
  logic [3:0] rsp_a = '0;

  initial for (int i = 0; i < 16; i++) model[i] = 32'hA000 + i;

  assign mem_rsp_valid = (rsp_cnt == 1);
  assign mem_rsp_data  = model[rsp_a];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_cnt > 0) rsp_cnt <= rsp_cnt - 1;
    if (!rst && mem_req_valid && ready_en) begin
      lg_we[lg_n]  <= mem_req_write;
      lg_a[lg_n]   <= mem_req_addr;
      lg_d[lg_n]   <= mem_req_wdata;
      lg_cyc[lg_n] <= cyc;
      lg_n <= lg_n + 1;
      if (mem_req_write) model[mem_req_addr[3:0]] <= mem_req_wdata;
      else begin
        rsp_cnt <= LAT;
        rsp_a   <= mem_req_addr[3:0];
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(wr_full == 1'b0, "R1 store taken", wr_full, 0);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(wr_full == 0, "R2 wr_full", wr_full, 0);
    chk(rd_ready == 1, "R2 rd_ready", rd_ready, 1);
    chk(mem_req_valid == 0, "R2 mem_req_valid", mem_req_valid, 0);
    chk(rd_resp_valid == 0, "R2 rd_resp_valid", rd_resp_valid, 0);
  endtask

  task automatic t_drain_order;
    int base;
    base = lg_n; ready_en = 1;
    wr1(16'h0100, 32'h11); wr1(16'h0104, 32'h22); wr1(16'h0108, 32'h33);
    settle(20);
    chk(lg_n - base == 3, "R3 store count", lg_n - base, 3);
    for (int k = 0; k < 3; k++) begin
      chk(lg_we[base+k] == 1, "R3 write flag", lg_we[base+k], 1);
      chk(lg_a[base+k] == 16'h0100 + 16'(4*k), "R3 order addr", lg_a[base+k], 16'h0100 + 4*k);
      chk(lg_d[base+k] == 32'h11 * (k+1), "R3 order data", lg_d[base+k], 32'h11 * (k+1));
    end
  endtask

  task automatic t_full;
    int base;
    logic [AW-1:0] a0;
    base = lg_n; ready_en = 0;
    for (int k = 0; k < 5; k++) wr1(16'h0200 + 16'(k), 32'hB0 + k);
    chk(wr_full == 1, "R1 full after DEPTH+1", wr_full, 1);
    a0 = mem_req_addr;
    settle(2);
    chk(mem_req_valid && mem_req_addr == a0, "R8 request held", mem_req_addr, a0);
    wr_valid = 1; wr_addr = 16'h0209; wr_data = 32'hDEAD;
    @(negedge clk);
    wr_valid = 0;
    ready_en = 1;
    settle(30);
    chk(wr_full == 0, "R1 full clears", wr_full, 0);
    chk(lg_n - base == 5, "R10 dropped store", lg_n - base, 5);
    for (int k = 0; k < 5; k++)
      chk(lg_d[base+k] == 32'hB0 + k, "R10 drained data", lg_d[base+k], 32'hB0 + k);
  endtask

  task automatic t_forward;
    int base;
    base = lg_n; ready_en = 0;
    wr1(16'h0010, 32'hAAAA); wr1(16'h0020, 32'hBBBB); wr1(16'h0010, 32'hCCCC);
    chk(rd_ready == 1, "R5 ready", rd_ready, 1);
    rd_valid = 1; rd_addr = 16'h0010;
    @(negedge clk);
    rd_valid = 0;
    chk(rd_resp_valid == 1, "R5 resp valid", rd_resp_valid, 1);
    chk(rd_resp_data == 32'hCCCC, "R5 youngest data", rd_resp_data, 32'hCCCC);
    @(negedge clk);
    chk(rd_resp_valid == 0, "R5 one cycle", rd_resp_valid, 0);
    ready_en = 1;
    settle(20);
    chk(lg_n - base == 3, "R5 no memory read", lg_n - base, 3);
    for (int k = 0; k < lg_n - base; k++)
      chk(lg_we[base+k] == 1, "R5 only stores", lg_we[base+k], 1);
  endtask

  task automatic t_miss_priority;
    int base, seen;
    base = lg_n; ready_en = 0;
    wr1(16'h0001, 32'h101); wr1(16'h0002, 32'h102); wr1(16'h0003, 32'h103);
    rd_valid = 1; rd_addr = 16'h0005;
    @(negedge clk);
    rd_valid = 0;
    chk(rd_ready == 0, "R7 ready low", rd_ready, 0);
    ready_en = 1;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (rd_resp_valid) seen = 1;
    end
    chk(seen == 1, "R6 response", seen, 1);
    chk(rd_resp_data == 32'hA005, "R6 data", rd_resp_data, 32'hA005);
    settle(20);
    chk(lg_we[base] == 1 && lg_a[base] == 16'h0001, "R4 presented store first", lg_a[base], 1);
    chk(lg_we[base+1] == 0 && lg_a[base+1] == 16'h0005, "R4 read next", lg_a[base+1], 5);
    chk(lg_cyc[base+2] > lg_cyc[base+1] + LAT, "R7 store after data", lg_cyc[base+2], lg_cyc[base+1] + LAT + 1);
    chk(lg_a[base+2] == 16'h0002 && lg_a[base+3] == 16'h0003, "R3 order after read", lg_a[base+3], 3);
  endtask

  task automatic t_same_cycle;
    logic [DW-1:0] old3;
    int seen;
    ready_en = 0;
    old3 = model[3];
    wr1(16'h0031, 32'h3131); wr1(16'h0042, 32'h4242);
    wr_valid = 1; wr_addr = 16'h0053; wr_data = 32'h5353;
    rd_valid = 1; rd_addr = 16'h0053;
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    chk(rd_resp_valid == 0 && rd_ready == 0, "R9 treated as miss", rd_resp_valid, 0);
    ready_en = 1;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (rd_resp_valid) seen = 1;
    end
    chk(seen == 1 && rd_resp_data == old3, "R9 read old data", rd_resp_data, old3);
    settle(20);
    chk(model[3] == 32'h5353, "R9 store lands after", model[3], 32'h5353);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_drain_order();
    t_full();
    t_forward();
    t_miss_priority();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule